// File: doc/BRIEF.md
# DRAM System Address Normalizer

This block decides whether a 40-bit physical address falls inside the memory owned by one node of a multi-node memory system. When it does, the block turns the address into the compact, zero-based input address that the node's DRAM controller compares against its chip-select bases. Three steps produce that address. The block first strips the hole that memory hoisting leaves below 4 GiB. It then subtracts the node base. It then removes the one to three address bits that spread consecutive 4 KiB pages across interleaved nodes.

All node setup values arrive as static inputs: base, limit, hole size, interleave mask and interleave select. A one-deep valid pipeline registers the result, so each accepted address gives a hit flag, a configuration-error flag and a 36-bit normalized address one clock later. Error-logging logic uses it by presenting the same failing address to the normalizer of every node. Exactly one node should answer with a hit. That node's normalized address then goes on to chip-select matching.

Top module: `dram_addr_normalizer`

## Requirements
- R1: A node whose base equals its limit never reports a hit, whatever the address.
- R2: An address hits only if base <= address <= limit, both ends inclusive. This comparison uses the address as presented, before any hole adjustment.
- R3: When the hole size is nonzero and the address is at or above 0x1_0000_0000, the hole size is subtracted from the address before the base is removed.
- R4: The node-relative address is the (possibly hole-adjusted) address minus the base with base bits [23:0] forced to zero.
- R5: The interleave mask accepts only the values 0, 1, 3 and 7. Any other value sets cfg_err and forces hit low.
- R6: With a nonzero mask, hit requires (adjusted address bits [14:12] AND mask) to equal the select value. With a zero mask the select value is ignored.
- R7: Normalized bits [35:12] take node-relative bits [35:12] for mask 0, [36:13] for mask 1, [37:14] for mask 3 and [38:15] for mask 7.
- R8: Normalized bits [11:0] always equal node-relative bits [11:0].
- R9: valid_out is valid_in delayed by exactly one clock, and the result for an address appears in that same cycle.
- R10: While valid_in is low, hit, cfg_err and norm_addr keep their previous values, whatever the other inputs do.
- R11: norm_addr reads zero whenever the registered hit is low.
- R12: A synchronous active-high reset clears valid_out, hit, cfg_err and norm_addr.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| valid_in | input | 1 | Address and setup are to be evaluated this cycle |
| phys_addr | input | 40 | Physical address to test |
| node_base | input | 40 | Lowest address owned by the node |
| node_limit | input | 40 | Highest address owned by the node |
| hole_size | input | 40 | Size of the hoisting hole, zero when unused |
| ilv_mask | input | 3 | Node interleave mask (0, 1, 3 or 7) |
| ilv_sel | input | 3 | This node's interleave position |
| valid_out | output | 1 | Result registers were loaded on the previous clock |
| hit | output | 1 | The address belongs to this node |
| cfg_err | output | 1 | The interleave mask value is illegal |
| norm_addr | output | 36 | Normalized controller input address |

## Verification
The base subtraction, the hole subtraction and the bit squeeze sit in front of a single register, so any fault in them shows up in norm_addr on the cycle after valid_in. Only a fault in the upper part of the squeeze stays confined to bits [35:12]. A wrong range or select decision shows up as a flipped hit flag, and norm_addr collapses to zero at the same time. A loss of the hold behaviour shows up as outputs that move while valid_in is low. The random vectors mix in-range and out-of-range addresses, legal and illegal masks, and hole on and off. Directed vectors sit exactly on each bound and on the 4 GiB hole threshold.

// File: rtl/dnorm_pkg.sv
package dnorm_pkg;

  // Width of the interleave mask and select fields.
  localparam int ILV_W = 3;

  typedef struct packed {
    logic hit;
    logic cfg_err;
  } dn_flags_t;

  // A legal mask is a run of ones starting at bit 0 (0, 1, 3, 7).
  function automatic logic ilv_mask_bad(input logic [ILV_W-1:0] m);
    logic [ILV_W-1:0] inc;
    inc = m + 1'b1;
    return (m & inc) != '0;
  endfunction

  // Number of interleave bits removed equals the ones in a legal mask.
  function automatic logic [1:0] ilv_drop_count(input logic [ILV_W-1:0] m);
    return 2'($countones(m));
  endfunction

endpackage

// File: rtl/dnorm_range_chk.sv
module dnorm_range_chk #(
  parameter int AW = 40
) (
  input  logic [AW-1:0] addr,
  input  logic [AW-1:0] base,
  input  logic [AW-1:0] limit,
  output logic          in_range
);

  logic empty_node;
  logic above_base;
  logic below_limit;

  always_comb begin
    empty_node  = (base == limit);
    above_base  = (addr >= base);
    below_limit = (addr <= limit);
    in_range    = !empty_node && above_base && below_limit;
  end

endmodule

// File: rtl/dnorm_rebase.sv
module dnorm_rebase #(
  parameter int AW        = 40,
  parameter int BASE_LSB  = 24,
  parameter int HOLE_BIT  = 32,
  parameter int PAGE_BITS = 12,
  parameter int SEL_W     = 3
) (
  input  logic [AW-1:0]          addr,
  input  logic [AW-BASE_LSB-1:0] base_hi,
  input  logic [AW-1:0]          hole,
  output logic [AW-1:0]          rel,
  output logic [SEL_W-1:0]       sel_bits
);

  localparam logic [AW-1:0] HOLE_START = {{(AW-1){1'b0}}, 1'b1} << HOLE_BIT;

  logic          hoisted;
  logic [AW-1:0] adj;
  logic [AW-1:0] base_aligned;

  always_comb begin
    hoisted      = (hole != '0) && (addr >= HOLE_START);
    adj          = hoisted ? (addr - hole) : addr;
    base_aligned = {base_hi, {BASE_LSB{1'b0}}};
    rel          = adj - base_aligned;
    sel_bits     = adj[PAGE_BITS +: SEL_W];
  end

endmodule

// File: rtl/dnorm_ilv_squeeze.sv
module dnorm_ilv_squeeze
  import dnorm_pkg::*;
#(
  parameter int PAGE_BITS = 12,
  parameter int UW        = 24,
  parameter int ILV_MAX   = 3,
  localparam int IN_W     = PAGE_BITS + ILV_MAX + UW,
  localparam int NW       = PAGE_BITS + UW
) (
  input  logic [IN_W-1:0]  rel,
  input  logic [ILV_W-1:0] sel_bits,
  input  logic [ILV_W-1:0] mask,
  input  logic [ILV_W-1:0] sel,
  output logic [NW-1:0]    norm,
  output logic             sel_ok,
  output logic             mask_bad
);

  logic [UW-1:0] cand [0:ILV_MAX];
  logic [1:0]    drop;
  logic [UW-1:0] upper;

  // One candidate upper field per possible number of removed bits.
  for (genvar k = 0; k <= ILV_MAX; k++) begin : g_cand
    assign cand[k] = rel[PAGE_BITS + k +: UW];
  end

  always_comb begin
    mask_bad = ilv_mask_bad(mask);
    drop     = ilv_drop_count(mask);
    upper    = cand[drop];
    norm     = {upper, rel[PAGE_BITS-1:0]};
    sel_ok   = (mask == '0) || ((sel_bits & mask) == sel);
  end

endmodule

// File: rtl/dram_addr_normalizer.sv
module dram_addr_normalizer
  import dnorm_pkg::*;
#(
  parameter int AW        = 40,
  parameter int BASE_LSB  = 24,
  parameter int HOLE_BIT  = 32,
  parameter int PAGE_BITS = 12,
  parameter int ILV_MAX   = 3,
  localparam int NW       = AW - 1 - ILV_MAX
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             valid_in,
  input  logic [AW-1:0]    phys_addr,
  input  logic [AW-1:0]    node_base,
  input  logic [AW-1:0]    node_limit,
  input  logic [AW-1:0]    hole_size,
  input  logic [ILV_W-1:0] ilv_mask,
  input  logic [ILV_W-1:0] ilv_sel,
  output logic             valid_out,
  output logic             hit,
  output logic             cfg_err,
  output logic [NW-1:0]    norm_addr
);

  localparam int UW   = NW - PAGE_BITS;
  localparam int IN_W = PAGE_BITS + ILV_MAX + UW;

  logic             in_range;
  logic [AW-1:0]    rel;
  logic [ILV_W-1:0] sel_bits;
  logic [NW-1:0]    norm_c;
  logic             sel_ok;
  logic             mask_bad;
  dn_flags_t        flags_c;

  dnorm_range_chk #(.AW(AW)) u_range (
    .addr     (phys_addr),
    .base     (node_base),
    .limit    (node_limit),
    .in_range (in_range)
  );

  dnorm_rebase #(
    .AW(AW), .BASE_LSB(BASE_LSB), .HOLE_BIT(HOLE_BIT),
    .PAGE_BITS(PAGE_BITS), .SEL_W(ILV_W)
  ) u_rebase (
    .addr     (phys_addr),
    .base_hi  (node_base[AW-1:BASE_LSB]),
    .hole     (hole_size),
    .rel      (rel),
    .sel_bits (sel_bits)
  );

  dnorm_ilv_squeeze #(
    .PAGE_BITS(PAGE_BITS), .UW(UW), .ILV_MAX(ILV_MAX)
  ) u_squeeze (
    .rel      (rel[IN_W-1:0]),
    .sel_bits (sel_bits),
    .mask     (ilv_mask),
    .sel      (ilv_sel),
    .norm     (norm_c),
    .sel_ok   (sel_ok),
    .mask_bad (mask_bad)
  );

  always_comb begin
    flags_c.cfg_err = mask_bad;
    flags_c.hit     = in_range && sel_ok && !mask_bad;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_out <= 1'b0;
      hit       <= 1'b0;
      cfg_err   <= 1'b0;
      norm_addr <= '0;
    end else begin
      valid_out <= valid_in;
      if (valid_in) begin
        hit       <= flags_c.hit;
        cfg_err   <= flags_c.cfg_err;
        norm_addr <= flags_c.hit ? norm_c : '0;
      end
    end
  end

endmodule

// File: rtl/dram_addr_normalizer_chk.sv
module dram_addr_normalizer_chk #(
  parameter int AW = 40,
  parameter int NW = 36
) (
  input logic          clk,
  input logic          rst,
  input logic          valid_in,
  input logic [AW-1:0] node_base,
  input logic [AW-1:0] node_limit,
  input logic [2:0]    ilv_mask,
  input logic          valid_out,
  input logic          hit,
  input logic          cfg_err,
  input logic [NW-1:0] norm_addr
);

  logic seen;

  always_ff @(posedge clk) begin
    if (rst) seen <= 1'b0;
    else     seen <= 1'b1;
  end

  p_latency_r9: assert property (@(posedge clk) disable iff (rst)
    seen |-> (valid_out == $past(valid_in)));

  p_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (seen && !$past(valid_in)) |->
      ($stable(hit) && $stable(cfg_err) && $stable(norm_addr)));

  p_err_blocks_hit_r5: assert property (@(posedge clk) disable iff (rst)
    (valid_out && cfg_err) |-> !hit);

  p_err_flag_r5: assert property (@(posedge clk) disable iff (rst)
    (seen && $past(valid_in)) |->
      (cfg_err == $past(ilv_mask != 3'd0 && ilv_mask != 3'd1 &&
                        ilv_mask != 3'd3 && ilv_mask != 3'd7)));

  p_empty_node_r1: assert property (@(posedge clk) disable iff (rst)
    (seen && $past(valid_in && node_base == node_limit)) |-> !hit);

  p_zero_on_miss_r11: assert property (@(posedge clk) disable iff (rst)
    !hit |-> (norm_addr == '0));

endmodule

bind dram_addr_normalizer dram_addr_normalizer_chk #(.AW(AW), .NW(NW)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .valid_in   (valid_in),
  .node_base  (node_base),
  .node_limit (node_limit),
  .ilv_mask   (ilv_mask),
  .valid_out  (valid_out),
  .hit        (hit),
  .cfg_err    (cfg_err),
  .norm_addr  (norm_addr)
);

// File: tb/dram_addr_normalizer_tb.sv
module dram_addr_normalizer_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        valid_in = 1'b0;
  logic [39:0] phys_addr = '0;
  logic [39:0] node_base = '0;
  logic [39:0] node_limit = '0;
  logic [39:0] hole_size = '0;
  logic [2:0]  ilv_mask = '0;
  logic [2:0]  ilv_sel = '0;
  logic        valid_out;
  logic        hit;
  logic        cfg_err;
  logic [35:0] norm_addr;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  dram_addr_normalizer u_dut (
    .clk(clk), .rst(rst), .valid_in(valid_in),
    .phys_addr(phys_addr), .node_base(node_base), .node_limit(node_limit),
    .hole_size(hole_size), .ilv_mask(ilv_mask), .ilv_sel(ilv_sel),
    .valid_out(valid_out), .hit(hit), .cfg_err(cfg_err), .norm_addr(norm_addr)
  );

  // Expected result from the requirements.
  function automatic void model(input logic [39:0] a, b, l, h,
                                input logic [2:0] m, s,
                                output logic e_hit, output logic e_err,
                                output logic [35:0] e_norm);
    logic [39:0] adj, rel;
    int drop;
    logic ok_range, ok_sel;
    adj = (h != 0 && a >= 40'h1_0000_0000) ? a - h : a;
    rel = adj - {b[39:24], 24'h0};
    case (m)
      3'd0: drop = 0;
      3'd1: drop = 1;
      3'd3: drop = 2;
      3'd7: drop = 3;
      default: drop = 0;
    endcase
    e_err = !(m == 0 || m == 1 || m == 3 || m == 7);
    ok_range = (b != l) && (a >= b) && (a <= l);
    ok_sel = (m == 0) || (((adj >> 12) & 40'(m)) == 40'(s));
    e_hit = ok_range && ok_sel && !e_err;
    e_norm = {24'((rel >> (12 + drop)) & 40'hFF_FFFF), rel[11:0]};
    if (!e_hit) e_norm = '0;
  endfunction

  task automatic chk1(input string tag, input string what,
                      input logic [39:0] act, input logic [39:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
    end
  endtask

  task automatic apply(input string tag, input logic [39:0] a, b, l, h,
                       input logic [2:0] m, s);
    logic e_hit, e_err;
    logic [35:0] e_norm;
    model(a, b, l, h, m, s, e_hit, e_err, e_norm);
    @(negedge clk);
    phys_addr = a; node_base = b; node_limit = l; hole_size = h;
    ilv_mask = m; ilv_sel = s; valid_in = 1'b1;
    @(negedge clk);
    valid_in = 1'b0;
    chk1("R9", "valid_out", 40'(valid_out), 40'd1);
    chk1(tag, "hit", 40'(hit), 40'(e_hit));
    chk1(e_err ? "R5" : tag, "cfg_err", 40'(cfg_err), 40'(e_err));
    chk1(e_hit ? tag : "R11", "norm_addr", 40'(norm_addr), 40'(e_norm));
  endtask

  initial begin
    #(20 * 150000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic h0, e0;
    logic [35:0] n0;
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R12: reset state
    chk1("R12", "valid_out", 40'(valid_out), 40'd0);
    chk1("R12", "hit", 40'(hit), 40'd0);
    chk1("R12", "norm_addr", 40'(norm_addr), 40'd0);

    // R1: empty node
    apply("R1", 40'h2_0000_0000, 40'h2_0000_0000, 40'h2_0000_0000, 0, 0, 0);
    // R2: inclusive bounds, one past each bound misses
    apply("R2", 40'h1_0000_0000, 40'h1_0000_0000, 40'h1_FFFF_FFFF, 0, 0, 0);
    apply("R2", 40'h1_FFFF_FFFF, 40'h1_0000_0000, 40'h1_FFFF_FFFF, 0, 0, 0);
    apply("R2", 40'h2_0000_0000, 40'h1_0000_0000, 40'h1_FFFF_FFFF, 0, 0, 0);
    apply("R2", 40'h0_FFFF_FFFF, 40'h1_0000_0000, 40'h1_FFFF_FFFF, 0, 0, 0);
    // R3: hole applied at and above 4 GiB, not below
    apply("R3", 40'h1_1000_0000, 0, 40'h1_2000_0000, 40'h4000_0000, 0, 0);
    apply("R3", 40'h1_0000_0000, 0, 40'h1_2000_0000, 40'h4000_0000, 0, 0);
    apply("R3", 40'h0_FFFF_F123, 0, 40'h1_2000_0000, 40'h4000_0000, 0, 0);
    // R4: base low bits dropped in the subtraction
    apply("R4", 40'h2_0000_6123, 40'h2_0000_5000, 40'h3_0000_0000, 0, 0, 0);
    // R5: illegal masks
    apply("R5", 40'h1000, 0, 40'hFF_FFFF, 0, 3'd2, 0);
    apply("R5", 40'h1000, 0, 40'hFF_FFFF, 0, 3'd5, 0);
    // R6: select compare, and select ignored with zero mask
    apply("R6", 40'h6000, 0, 40'hFF_FFFF, 0, 3'd3, 3'd2);
    apply("R6", 40'h5000, 0, 40'hFF_FFFF, 0, 3'd3, 3'd2);
    apply("R6", 40'h5000, 0, 40'hFF_FFFF, 0, 3'd0, 3'd6);
    // R7 and R8: each squeeze width on a patterned address
    apply("R7", 40'h12_3456_7ABC, 0, 40'hFF_FFFF_FFFF, 0, 3'd0, 0);
    apply("R7", 40'h12_3456_7ABC, 0, 40'hFF_FFFF_FFFF, 0, 3'd1, 3'd1);
    apply("R7", 40'h12_3456_7ABC, 0, 40'hFF_FFFF_FFFF, 0, 3'd3, 3'd3);
    apply("R8", 40'h12_3456_7ABC, 0, 40'hFF_FFFF_FFFF, 0, 3'd7, 3'd7);

    // R10: outputs hold while valid_in is low
    model(40'h12_3456_7ABC, 0, 40'hFF_FFFF_FFFF, 0, 3'd7, 3'd7, h0, e0, n0);
    @(negedge clk);
    phys_addr = 40'h1; node_base = 40'h5; node_limit = 40'h5; ilv_mask = 3'd6;
    @(negedge clk);
    chk1("R10", "valid_out", 40'(valid_out), 40'd0);
    chk1("R10", "hit", 40'(hit), 40'(h0));
    chk1("R10", "cfg_err", 40'(cfg_err), 40'(e0));
    chk1("R10", "norm_addr", 40'(norm_addr), 40'(n0));

    // Random mix
    for (int i = 0; i < 600; i++) begin
      logic [39:0] b, l, a, h, span;
      logic [2:0] m, s;
      b = {2'b0, 6'($urandom), 32'($urandom)};
      span = {4'b0, 4'($urandom), 32'($urandom)};
      if ($urandom % 16 == 0) span = 0;
      l = b + span;
      if ($urandom % 4 == 0) a = {8'($urandom), 32'($urandom)};
      else a = b + ({8'b0, 32'($urandom)} % (span + 1));
      h = ($urandom % 2 == 0) ? 40'h0 : {8'b0, 8'($urandom), 24'h0};
      case ($urandom % 5)
        0: m = 3'd0;
        1: m = 3'd1;
        2: m = 3'd3;
        3: m = 3'd7;
        default: m = 3'($urandom);
      endcase
      s = ($urandom % 4 == 0) ? 3'($urandom) : (3'(a >> 12) & m);
      apply("R7", a, b, l, h, m, s);
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule